// File: doc/BRIEF.md
# External Bus Pin State Controller

This block owns the address, data, strobe, byte-high, chip-select and latch-enable pins of a non-multiplexed bus with a 20-bit address and 16-bit data. A requester inside the chip presents one access at a time: an address, a direction, byte enables, write data, a region code and a wait-state choice. The block runs a bus cycle for that access and decides, for every pin, what the outside world sees. The region code tells it whether the access targets on-chip peripheral registers, on-chip memory or an off-chip device.

Peripheral-register and off-chip accesses appear on the pins. The address is presented for the whole cycle, the data lines carry write data or float for a read, and the read or write strobes fall after one setup period. Off-chip accesses also pull low the chip select that matches the top address bits. On-chip memory accesses are hidden. The address and byte-high pins keep the values from the last visible access, every strobe and chip select stays high, and the data lines float. Each cycle lasts two or three clock periods. A one-clock done pulse marks its last period, and the next request is taken only once the controller is idle again.

The sequencer has four states. `ST_IDLE` moves to `ST_SETUP` when a request is valid (the accept transition). `ST_SETUP` always moves to `ST_STROBE1`. `ST_STROBE1` moves to `ST_STROBE2` when two wait states were latched, and otherwise back to `ST_IDLE`. `ST_STROBE2` always returns to `ST_IDLE`.

Top module: `xbus_pin_ctrl`

## Requirements
- R1: After reset the address pins are all zero, the read, write, low-write, high-write and byte-high pins are high, all four chip selects are high, the data output enable is low and done is low.
- R2: During every period of a peripheral-register cycle (region code 1), the address pins carry the request address, all four chip selects are high and the latch-enable pin is low.
- R3: For a visible read, the data output enable stays low for the whole cycle, the read strobe is low only in the strobe periods, and all write strobes stay high.
- R4: For a visible write, the data pins carry the write data with the output enable high in every period of the cycle. In the strobe periods the low-write pin is low if and only if byte enable bit 0 is set, the high-write pin is low if and only if byte enable bit 1 is set, and the write pin is low if either of them is low. The read strobe stays high.
- R5: A visible access sets the byte-high pin to the inverse of byte enable bit 1 from the setup period on, and the pin keeps that value until the next visible access.
- R6: An on-chip memory access (region code 0, and also the unused code 3) leaves the address and byte-high pins at their previous values. It keeps all strobes and chip selects high, keeps the data output enable low and keeps latch-enable low.
- R7: With one wait state selected (wait input 0), a cycle lasts two periods: one setup period with the strobes high, then one period with the strobe low.
- R8: With two wait states selected (wait input 1), a cycle lasts three periods: one setup period, then two periods with the strobe low.
- R9: Done is high for exactly the last period of each cycle, and the strobes are released in the period that follows it.
- R10: For an off-chip access (region code 2), chip select number addr[19:18] is low in every period of the cycle and the other three are high. Strobe timing is the same as for a peripheral-register access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request; taken only while idle |
| req_addr | input | 20 | Access address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_be | input | 2 | Byte enables: bit 0 is the low byte, bit 1 the high byte |
| req_wdata | input | 16 | Write data |
| req_region | input | 2 | 0 on-chip memory, 1 peripheral register, 2 off-chip, 3 treated as 0 |
| req_wait2 | input | 1 | 0 selects one wait state, 1 selects two |
| req_done | output | 1 | High in the last period of a cycle |
| pin_addr | output | 20 | Address pins |
| pin_data_oe | output | 1 | Data pin output enable (0 means high impedance) |
| pin_data_out | output | 16 | Data pin output value |
| pin_rd_n | output | 1 | Read strobe, active low |
| pin_wr_n | output | 1 | Combined write strobe, active low |
| pin_wrl_n | output | 1 | Low-byte write strobe, active low |
| pin_wrh_n | output | 1 | High-byte write strobe, active low |
| pin_bhe_n | output | 1 | Byte-high enable, active low |
| pin_cs_n | output | 4 | Chip selects, active low |
| pin_ale | output | 1 | Address latch enable, held low |

## Verification
The bench follows a visible access with a hidden one and checks that the address and byte-high pins keep their earlier values. A design that copied every request onto the pins would show the hidden address there. It checks strobes in each period of both cycle lengths, so a strobe that falls in the setup period, or a missing third period, shows up as a pin mismatch. Writes to a single byte check that only the matching lane strobe moves and that byte-high follows bit 1. Off-chip cycles at the highest and a middle address window check the chip-select decode, and region code 3 must behave like a hidden access rather than an off-chip one.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        RGN_INTERNAL = 2'd0,
        RGN_SFR      = 2'd1,
        RGN_EXTERNAL = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE1 = 2'd2,
        ST_STROBE2 = 2'd3
    } bus_state_e;

    function automatic logic region_visible(input logic [1:0] rgn);
        return (rgn == RGN_SFR) || (rgn == RGN_EXTERNAL);
    endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_wait2,
    output bus_state_e state,
    output logic       accept,
    output logic       done
);

    bus_state_e state_nxt;
    logic       wait2_q;

    assign accept = (state == ST_IDLE) && req_valid;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_nxt = ST_SETUP;
            ST_SETUP:   state_nxt = ST_STROBE1;
            ST_STROBE1: state_nxt = wait2_q ? ST_STROBE2 : ST_IDLE;
            ST_STROBE2: state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wait2_q <= 1'b0;
        end else begin
            state <= state_nxt;
            if (accept) wait2_q <= req_wait2;
        end
    end

    always_comb begin
        done = 1'b0;
        unique case (state)
            ST_IDLE:    done = 1'b0;
            ST_SETUP:   done = 1'b0;
            ST_STROBE1: done = !wait2_q;
            ST_STROBE2: done = 1'b1;
            default:    done = 1'b0;
        endcase
    end

endmodule

// File: rtl/xbus_req_reg.sv
module xbus_req_reg #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  logic [BE_W-1:0]   in_be,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [1:0]        in_region,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_write,
    output logic [BE_W-1:0]   cur_be,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [1:0]        cur_region
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            cur_write  <= 1'b0;
            cur_be     <= '0;
            cur_wdata  <= '0;
            cur_region <= 2'd0;
        end else if (accept) begin
            cur_addr   <= in_addr;
            cur_write  <= in_write;
            cur_be     <= in_be;
            cur_wdata  <= in_wdata;
            cur_region <= in_region;
        end
    end

endmodule

// File: rtl/xbus_hold.sv
module xbus_hold #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic              new_hi_byte,
    output logic [ADDR_W-1:0] held_addr,
    output logic              held_bhe_n
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_addr  <= '0;
            held_bhe_n <= 1'b1;
        end else if (load) begin
            held_addr  <= new_addr;
            held_bhe_n <= !new_hi_byte;
        end
    end

endmodule

// File: rtl/xbus_cs_dec.sv
module xbus_cs_dec #(
    parameter int ADDR_W = 20,
    parameter int CS_N   = 4
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr,
    output logic [CS_N-1:0]   cs_n
);

    localparam int SEL_W = (CS_N > 1) ? $clog2(CS_N) : 1;

    logic [SEL_W-1:0] sel;
    assign sel = addr[ADDR_W-1 -: SEL_W];

    for (genvar g = 0; g < CS_N; g++) begin : g_cs
        assign cs_n[g] = !(enable && (sel == SEL_W'(g)));
    end

endmodule

// File: rtl/xbus_pin_ctrl.sv
module xbus_pin_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CS_N   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_region,
    input  logic              req_wait2,
    output logic              req_done,
    output logic [ADDR_W-1:0] pin_addr,
    output logic              pin_data_oe,
    output logic [DATA_W-1:0] pin_data_out,
    output logic              pin_rd_n,
    output logic              pin_wr_n,
    output logic              pin_wrl_n,
    output logic              pin_wrh_n,
    output logic              pin_bhe_n,
    output logic [CS_N-1:0]   pin_cs_n,
    output logic              pin_ale
);

    localparam int BE_W = 2;

    bus_state_e        state;
    logic              accept;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_write;
    logic [BE_W-1:0]   cur_be;
    logic [DATA_W-1:0] cur_wdata;
    logic [1:0]        cur_region;
    logic [ADDR_W-1:0] held_addr;
    logic              held_bhe_n;
    logic              cur_vis;
    logic              cur_ext;
    logic              in_cycle;
    logic              strobe_on;
    logic [CS_N-1:0]   dec_cs_n;

    xbus_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_wait2 (req_wait2),
        .state     (state),
        .accept    (accept),
        .done      (req_done)
    );

    xbus_req_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .in_addr    (req_addr),
        .in_write   (req_write),
        .in_be      (req_be),
        .in_wdata   (req_wdata),
        .in_region  (req_region),
        .cur_addr   (cur_addr),
        .cur_write  (cur_write),
        .cur_be     (cur_be),
        .cur_wdata  (cur_wdata),
        .cur_region (cur_region)
    );

    xbus_hold #(
        .ADDR_W (ADDR_W)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept && region_visible(req_region)),
        .new_addr    (req_addr),
        .new_hi_byte (req_be[BE_W-1]),
        .held_addr   (held_addr),
        .held_bhe_n  (held_bhe_n)
    );

    xbus_cs_dec #(
        .ADDR_W (ADDR_W),
        .CS_N   (CS_N)
    ) u_cs (
        .enable (in_cycle && cur_ext),
        .addr   (cur_addr),
        .cs_n   (dec_cs_n)
    );

    assign cur_vis = region_visible(cur_region);
    assign cur_ext = (cur_region == RGN_EXTERNAL);

    always_comb begin
        in_cycle  = 1'b0;
        strobe_on = 1'b0;
        unique case (state)
            ST_IDLE:    begin in_cycle = 1'b0; strobe_on = 1'b0; end
            ST_SETUP:   begin in_cycle = 1'b1; strobe_on = 1'b0; end
            ST_STROBE1: begin in_cycle = 1'b1; strobe_on = 1'b1; end
            ST_STROBE2: begin in_cycle = 1'b1; strobe_on = 1'b1; end
            default:    begin in_cycle = 1'b0; strobe_on = 1'b0; end
        endcase
    end

    always_comb begin
        pin_addr     = held_addr;
        pin_bhe_n    = held_bhe_n;
        pin_ale      = 1'b0;
        pin_cs_n     = dec_cs_n;
        pin_data_oe  = in_cycle && cur_vis && cur_write;
        pin_data_out = pin_data_oe ? cur_wdata : '0;
        pin_rd_n     = !(strobe_on && cur_vis && !cur_write);
        pin_wrl_n    = !(strobe_on && cur_vis && cur_write && cur_be[0]);
        pin_wrh_n    = !(strobe_on && cur_vis && cur_write && cur_be[BE_W-1]);
        pin_wr_n     = pin_wrl_n && pin_wrh_n;
    end

endmodule

// File: rtl/xbus_pin_ctrl_chk.sv
module xbus_pin_ctrl_chk #(
    parameter int ADDR_W = 20,
    parameter int CS_N   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_done,
    input logic [ADDR_W-1:0] pin_addr,
    input logic              pin_data_oe,
    input logic              pin_rd_n,
    input logic              pin_wr_n,
    input logic [CS_N-1:0]   pin_cs_n
);

    AST_RD_FLOATS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_rd_n |-> !pin_data_oe); // R3

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pin_rd_n && !pin_wr_n)); // R3

    AST_WR_DRIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_wr_n |-> pin_data_oe); // R4

    AST_ADDR_SETTLED_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_rd_n |-> $stable(pin_addr)); // R7

    AST_ADDR_SETTLED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_wr_n |-> $stable(pin_addr)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done); // R9

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> (pin_rd_n && pin_wr_n)); // R9

    AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pin_cs_n)); // R10

endmodule

bind xbus_pin_ctrl xbus_pin_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .CS_N   (CS_N)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_done    (req_done),
    .pin_addr    (pin_addr),
    .pin_data_oe (pin_data_oe),
    .pin_rd_n    (pin_rd_n),
    .pin_wr_n    (pin_wr_n),
    .pin_cs_n    (pin_cs_n)
);

// File: tb/tb_xbus_pin_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_pin_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_region = '0;
    logic        req_wait2 = 1'b0;
    logic        req_done;
    logic [19:0] pin_addr;
    logic        pin_data_oe;
    logic [15:0] pin_data_out;
    logic        pin_rd_n, pin_wr_n, pin_wrl_n, pin_wrh_n, pin_bhe_n, pin_ale;
    logic [3:0]  pin_cs_n;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    xbus_pin_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
        .req_region(req_region), .req_wait2(req_wait2), .req_done(req_done),
        .pin_addr(pin_addr), .pin_data_oe(pin_data_oe), .pin_data_out(pin_data_out),
        .pin_rd_n(pin_rd_n), .pin_wr_n(pin_wr_n), .pin_wrl_n(pin_wrl_n),
        .pin_wrh_n(pin_wrh_n), .pin_bhe_n(pin_bhe_n), .pin_cs_n(pin_cs_n),
        .pin_ale(pin_ale)
    );

    typedef struct packed {
        logic [19:0] addr;
        logic        oe;
        logic [15:0] data;
        logic        rd_n, wr_n, wrl_n, wrh_n, bhe_n;
        logic [3:0]  cs_n;
        logic        ale, done;
    } pins_t;

    typedef struct {
        pins_t exp;
        string tag;
    } item_t;

    item_t q[$];

    logic [19:0] mdl_addr = '0;
    logic        mdl_bhe_n = 1'b1;

    function automatic pins_t observe();
        pins_t p;
        p.addr = pin_addr; p.oe = pin_data_oe;
        p.data = pin_data_oe ? pin_data_out : 16'h0;
        p.rd_n = pin_rd_n; p.wr_n = pin_wr_n; p.wrl_n = pin_wrl_n;
        p.wrh_n = pin_wrh_n; p.bhe_n = pin_bhe_n; p.cs_n = pin_cs_n;
        p.ale = pin_ale; p.done = req_done;
        return p;
    endfunction

    task automatic compare(input pins_t exp, input string tag);
        pins_t act;
        act = observe();
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual addr=%h oe=%b data=%h rd=%b wr=%b wrl=%b wrh=%b bhe=%b cs=%b ale=%b done=%b expected addr=%h oe=%b data=%h rd=%b wr=%b wrl=%b wrh=%b bhe=%b cs=%b ale=%b done=%b",
                tag, act.addr, act.oe, act.data, act.rd_n, act.wr_n, act.wrl_n, act.wrh_n,
                act.bhe_n, act.cs_n, act.ale, act.done, exp.addr, exp.oe, exp.data,
                exp.rd_n, exp.wr_n, exp.wrl_n, exp.wrh_n, exp.bhe_n, exp.cs_n, exp.ale, exp.done);
        end
    endtask

    // Monitor: one expected item per period, compared away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                compare(it.exp, it.tag);
            end
        end
    end

    function automatic pins_t idle_pins();
        pins_t p;
        p = '0;
        p.addr = mdl_addr; p.bhe_n = mdl_bhe_n;
        p.rd_n = 1'b1; p.wr_n = 1'b1; p.wrl_n = 1'b1; p.wrh_n = 1'b1;
        p.cs_n = 4'hF;
        return p;
    endfunction

    // Driver: called at a falling edge while the controller is idle.
    task automatic access(input logic [1:0] rgn, input logic [19:0] addr,
                          input logic wr, input logic [1:0] be,
                          input logic [15:0] wd, input logic w2, input string tag);
        bit vis, ext;
        int periods;
        vis = (rgn == 2'd1) || (rgn == 2'd2);
        ext = (rgn == 2'd2);
        periods = w2 ? 3 : 2;
        req_valid = 1'b1; req_addr = addr; req_write = wr; req_be = be;
        req_wdata = wd; req_region = rgn; req_wait2 = w2;
        @(negedge clk);
        req_valid = 1'b0;
        if (vis) begin
            mdl_addr  = addr;
            mdl_bhe_n = !be[1];
        end
        for (int i = 0; i < periods; i++) begin
            item_t it;
            pins_t p;
            p = idle_pins();
            if (vis && wr) begin p.oe = 1'b1; p.data = wd; end
            if (ext) p.cs_n = ~(4'b0001 << addr[19:18]);
            if (i > 0 && vis) begin
                if (wr) begin
                    p.wrl_n = !be[0];
                    p.wrh_n = !be[1];
                    p.wr_n  = !(be[0] || be[1]);
                end else begin
                    p.rd_n = 1'b0;
                end
            end
            p.done = (i == periods - 1);
            it.exp = p;
            it.tag = $sformatf("%s period %0d", tag, i);
            q.push_back(it);
        end
        begin
            item_t it;
            it.exp = idle_pins();
            it.tag = {tag, " after"};
            q.push_back(it);
        end
        for (int i = 0; i < periods; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        compare(idle_pins(), "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R7 R5: peripheral read, one wait, both bytes
        access(2'd1, 20'h12345, 1'b0, 2'b11, 16'h0000, 1'b0, "R2 R3 R7 R5 sfr read");
        // R4 R8 R5: peripheral write low byte, two waits
        access(2'd1, 20'h00400, 1'b1, 2'b01, 16'hA5A5, 1'b1, "R4 R8 R5 sfr write low");
        // R6: hidden read keeps address and byte-high
        access(2'd0, 20'h7FFFE, 1'b0, 2'b11, 16'h0000, 1'b0, "R6 internal read");
        // R4 R5 R9: peripheral write high byte, one wait
        access(2'd1, 20'h00401, 1'b1, 2'b10, 16'h3C00, 1'b0, "R4 R5 R9 sfr write high");
        // R6: hidden write, two waits, data must float
        access(2'd0, 20'hFFFFF, 1'b1, 2'b01, 16'hFFFF, 1'b1, "R6 internal write");
        // R10 R8: off-chip read, top window
        access(2'd2, 20'hC1234, 1'b0, 2'b11, 16'h0000, 1'b1, "R10 R8 ext read cs3");
        // R10 R4 R7: off-chip write both bytes, window 1
        access(2'd2, 20'h40010, 1'b1, 2'b11, 16'h1234, 1'b0, "R10 R4 R7 ext write cs1");
        // R6: unused region code behaves as hidden
        access(2'd3, 20'h80000, 1'b1, 2'b11, 16'hBEEF, 1'b0, "R6 region3 hidden");
        // R9 R3: back-to-back peripheral read, two waits
        access(2'd1, 20'h003FF, 1'b0, 2'b01, 16'h0000, 1'b1, "R9 R3 sfr read low");

        repeat (3) @(negedge clk);
        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule